// File: doc/BRIEF.md
# Hypervisor-Aware Trap Entry Unit

This block works out every architectural update a hart with virtualization support makes when it takes an exception or an interrupt. Each cycle it receives a trap request: a cause code, a flag that marks the request as an interrupt, the faulting address with a flag saying whether that address is meaningful, and a guest-physical fault address. It also receives the current pc, the privilege level and the virtualization state, the two delegation masks, and the two trap-vector registers. From these it decides whether the trap is handled at supervisor or at machine level.

All results are combinational. The unit drives write strobes for the supervisor and machine trap registers, along with the values for them: the cause word, the saved pc, the trap value, a second trap value for the guest-physical address, and the saved previous-virtualization bit. It also drives the privilege, the virtualization flag and the pc that follow the trap. The surrounding CSR file and pc register commit these values in the single cycle in which the trap-valid input is high. When trap-valid is low, both strobes are low and the privilege, virtualization and pc outputs repeat the current values.

Top module: `trap_entry_unit`

## Requirements
- R1: The delegation mask is `irq_deleg` for interrupts (`trap_is_irq`=1) and `exc_deleg` for exceptions. The mask bit used is the one at index `trap_code`.
- R2: The trap goes to supervisor level only when `cur_priv` is U (2'b00) or S (2'b01) and the selected mask bit is 1. From M (2'b11), or when the bit is 0, it goes to machine level.
- R3: While `trap_valid`=1, exactly one of `s_commit` or `m_commit` is high, and it matches the target. While `trap_valid`=0, both are low and `next_priv`, `next_virt` and `next_pc` equal `cur_priv`, `cur_virt` and `cur_pc`.
- R4: `cause_o` holds `trap_code` in bits [CAUSE_W-1:0] and `trap_is_irq` in bit XLEN-1. Every other bit is zero.
- R5: `next_pc` on a trap is the target's vector base with bits [1:0] cleared. When the trap is an interrupt and the vector's bits [1:0] equal 2'b01, cause×4 is added to it. Otherwise nothing is added.
- R6: `tval_o` equals `fault_addr` only for an exception with `trap_has_addr`=1. Otherwise it is zero.
- R7: For a supervisor-level trap, `htval_o` equals `gpa_addr` and `mtval2_o` is zero. For a machine-level trap, `mtval2_o` equals `gpa_addr` and `htval_o` is zero.
- R8: `prev_virt_o` equals `cur_virt` on every supervisor-level trap.
- R9: `next_virt` is 0 on every trap, whichever level the trap goes to and whatever `cur_virt` was.
- R10: `epc_o` equals `cur_pc`. On a trap, `next_priv` is 2'b01 for a supervisor-level target and 2'b11 for a machine-level target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | CAUSE_W | Cause code |
| trap_has_addr | input | 1 | The exception carries a faulting address |
| fault_addr | input | XLEN | Faulting address |
| gpa_addr | input | XLEN | Guest-physical fault address |
| cur_pc | input | XLEN | pc of the trapping instruction |
| cur_priv | input | 2 | Current privilege (U=00, S=01, M=11) |
| cur_virt | input | 1 | Virtualization currently enabled |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| exc_deleg | input | XLEN | Exception delegation mask |
| s_vec | input | XLEN | Supervisor trap-vector register |
| m_vec | input | XLEN | Machine trap-vector register |
| s_commit | output | 1 | Write strobe for the supervisor trap registers and the previous-virtualization bit |
| m_commit | output | 1 | Write strobe for the machine trap registers |
| cause_o | output | XLEN | Cause word |
| epc_o | output | XLEN | Saved pc |
| tval_o | output | XLEN | Trap value |
| htval_o | output | XLEN | Guest-physical trap value for the supervisor target |
| mtval2_o | output | XLEN | Guest-physical trap value for the machine target |
| prev_virt_o | output | 1 | Saved virtualization state |
| next_priv | output | 2 | Privilege after this cycle |
| next_virt | output | 1 | Virtualization flag after this cycle |
| next_pc | output | XLEN | pc after this cycle |

## Verification
The embedded assertions check the following on every clocked cycle:
- the strobes are mutually exclusive and consistent with `trap_valid`;
- the idle outputs repeat the current state;
- the virtualization flag is cleared and the new privilege matches the strobe;
- the guest-physical address goes into exactly one of the two second trap values;
- the sign bit of the cause follows the interrupt flag;
- tval is zero for interrupts;
- the aligned vector base is used.

The interaction between the delegation masks, the cause index and the current privilege can only be shown by the bench. The same is true of the vectored offset arithmetic and of the exact routed values. The bench therefore sweeps every cause code under every privilege, virtualization state, trap kind and vector mode.

// File: rtl/trap_pkg.sv
package trap_pkg;

   typedef enum logic [1:0] {
      LVL_U = 2'b00,
      LVL_S = 2'b01,
      LVL_M = 2'b11
   } lvl_t;

   localparam logic [1:0] VMODE_VECTORED = 2'b01;

endpackage

// File: rtl/trap_deleg_sel.sv
module trap_deleg_sel #(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 5
) (
   input  logic [XLEN-1:0]    irq_mask,
   input  logic [XLEN-1:0]    exc_mask,
   input  logic               is_irq,
   input  logic [CAUSE_W-1:0] code,
   input  logic [1:0]         priv,
   output logic               to_super
);
   import trap_pkg::*;

   localparam int IDX_W = $clog2(XLEN);

   logic [XLEN-1:0]  mask_sel;
   logic [IDX_W-1:0] bit_idx;
   logic             bit_set;
   logic             low_priv;

   generate
      if (CAUSE_W >= IDX_W) begin : g_trunc
         assign bit_idx = code[IDX_W-1:0];
      end else begin : g_ext
         assign bit_idx = {{(IDX_W-CAUSE_W){1'b0}}, code};
      end
   endgenerate

   always_comb begin
      mask_sel = is_irq ? irq_mask : exc_mask;
      bit_set  = mask_sel[bit_idx];
      low_priv = (priv == LVL_U) || (priv == LVL_S);
      to_super = low_priv && bit_set;
   end

endmodule

// File: rtl/trap_cause_fmt.sv
module trap_cause_fmt #(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 5
) (
   input  logic               is_irq,
   input  logic [CAUSE_W-1:0] code,
   output logic [XLEN-1:0]    cause
);
   localparam int PAD_W = XLEN - CAUSE_W - 1;

   assign cause = {is_irq, {PAD_W{1'b0}}, code};

endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen #(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 5
) (
   input  logic [XLEN-1:0]    vec_reg,
   input  logic               is_irq,
   input  logic [CAUSE_W-1:0] code,
   output logic [XLEN-1:0]    target
);
   import trap_pkg::*;

   localparam int OFS_PAD = XLEN - CAUSE_W - 2;

   logic [XLEN-1:0] base;
   logic [XLEN-1:0] offset;
   logic            use_ofs;

   always_comb begin
      base    = {vec_reg[XLEN-1:2], 2'b00};
      use_ofs = is_irq && (vec_reg[1:0] == VMODE_VECTORED);
      offset  = use_ofs ? {{OFS_PAD{1'b0}}, code, 2'b00} : '0;
      target  = base + offset;
   end

endmodule

// File: rtl/trap_addr_route.sv
module trap_addr_route #(
   parameter int XLEN = 32
) (
   input  logic            is_irq,
   input  logic            has_addr,
   input  logic            to_super,
   input  logic [XLEN-1:0] fault,
   input  logic [XLEN-1:0] gpa,
   output logic [XLEN-1:0] tval,
   output logic [XLEN-1:0] hval,
   output logic [XLEN-1:0] mval2
);

   always_comb begin
      tval  = (!is_irq && has_addr) ? fault : '0;
      hval  = to_super ? gpa : '0;
      mval2 = to_super ? '0 : gpa;
   end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_valid,
   input  logic               trap_is_irq,
   input  logic [CAUSE_W-1:0] trap_code,
   input  logic               trap_has_addr,
   input  logic [XLEN-1:0]    fault_addr,
   input  logic [XLEN-1:0]    gpa_addr,
   input  logic [XLEN-1:0]    cur_pc,
   input  logic [1:0]         cur_priv,
   input  logic               cur_virt,
   input  logic [XLEN-1:0]    irq_deleg,
   input  logic [XLEN-1:0]    exc_deleg,
   input  logic [XLEN-1:0]    s_vec,
   input  logic [XLEN-1:0]    m_vec,
   output logic               s_commit,
   output logic               m_commit,
   output logic [XLEN-1:0]    cause_o,
   output logic [XLEN-1:0]    epc_o,
   output logic [XLEN-1:0]    tval_o,
   output logic [XLEN-1:0]    htval_o,
   output logic [XLEN-1:0]    mtval2_o,
   output logic               prev_virt_o,
   output logic [1:0]         next_priv,
   output logic               next_virt,
   output logic [XLEN-1:0]    next_pc
);
   import trap_pkg::*;

   localparam int NLVL = 2;

   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("trap_entry_unit: XLEN must be 32 or 64");
      end
      if (CAUSE_W < 1 || CAUSE_W > $clog2(XLEN)) begin : g_bad_cause
         $error("trap_entry_unit: CAUSE_W out of range");
      end
   endgenerate

   logic                to_super;
   logic [XLEN-1:0]     lvl_pc [NLVL];
   logic [XLEN-1:0]     lvl_vec[NLVL];

   // delegation decision
   trap_deleg_sel #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_deleg (
      .irq_mask (irq_deleg),
      .exc_mask (exc_deleg),
      .is_irq   (trap_is_irq),
      .code     (trap_code),
      .priv     (cur_priv),
      .to_super (to_super)
   );

   // cause word
   trap_cause_fmt #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_cause (
      .is_irq (trap_is_irq),
      .code   (trap_code),
      .cause  (cause_o)
   );

   // one vector generator per target level: index 0 = supervisor, 1 = machine
   assign lvl_vec[0] = s_vec;
   assign lvl_vec[1] = m_vec;

   generate
      for (genvar g = 0; g < NLVL; g++) begin : g_lvl
         trap_vec_gen #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
            .vec_reg (lvl_vec[g]),
            .is_irq  (trap_is_irq),
            .code    (trap_code),
            .target  (lvl_pc[g])
         );
      end
   endgenerate

   // trap value routing
   trap_addr_route #(.XLEN(XLEN)) u_route (
      .is_irq   (trap_is_irq),
      .has_addr (trap_has_addr),
      .to_super (to_super),
      .fault    (fault_addr),
      .gpa      (gpa_addr),
      .tval     (tval_o),
      .hval     (htval_o),
      .mval2    (mtval2_o)
   );

   // commit and next-state selection
   always_comb begin
      s_commit    = trap_valid &&  to_super;
      m_commit    = trap_valid && !to_super;
      epc_o       = cur_pc;
      prev_virt_o = cur_virt;
      if (trap_valid) begin
         next_priv = to_super ? LVL_S : LVL_M;
         next_virt = 1'b0;
         next_pc   = to_super ? lvl_pc[0] : lvl_pc[1];
      end else begin
         next_priv = cur_priv;
         next_virt = cur_virt;
         next_pc   = cur_pc;
      end
   end

   // ---------------- embedded checks ----------------
   a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> $onehot({s_commit, m_commit}));

   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_valid |-> (!s_commit && !m_commit && next_pc == cur_pc
                       && next_priv == cur_priv && next_virt == cur_virt));

   a_r9_virt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> !next_virt);

   a_r10_priv_match: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> (s_commit ? next_priv == 2'b01 : next_priv == 2'b11));

   a_r7_gpa_one_side: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> (s_commit ? (mtval2_o == '0 && htval_o == gpa_addr)
                               : (htval_o == '0 && mtval2_o == gpa_addr)));

   a_r4_sign_bit: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> (cause_o[XLEN-1] == trap_is_irq));

   a_r6_irq_no_tval: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_is_irq) |-> (tval_o == '0));

   a_r2_m_stays_m: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && cur_priv == 2'b11) |-> m_commit);

   a_r5_plain_base: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && !trap_is_irq) |->
         (next_pc == (s_commit ? {s_vec[XLEN-1:2], 2'b00} : {m_vec[XLEN-1:2], 2'b00})));

endmodule

// File: tb/sim_trap_entry_unit.sv
module sim_trap_entry_unit;
   localparam int XL    = 32;
   localparam int CW    = 5;
   localparam int CLK_P = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trap_valid = 1'b0, trap_is_irq = 1'b0, trap_has_addr = 1'b0;
   logic [CW-1:0] trap_code = '0;
   logic [XL-1:0] fault_addr = '0, gpa_addr = '0, cur_pc = '0;
   logic [1:0]    cur_priv = 2'b11;
   logic          cur_virt = 1'b0;
   logic [XL-1:0] irq_deleg = '0, exc_deleg = '0, s_vec = '0, m_vec = '0;
   logic          s_commit, m_commit, prev_virt_o, next_virt;
   logic [XL-1:0] cause_o, epc_o, tval_o, htval_o, mtval2_o, next_pc;
   logic [1:0]    next_priv;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   trap_entry_unit #(.XLEN(XL), .CAUSE_W(CW)) u0 (
      .clk, .rst_n, .trap_valid, .trap_is_irq, .trap_code, .trap_has_addr,
      .fault_addr, .gpa_addr, .cur_pc, .cur_priv, .cur_virt, .irq_deleg,
      .exc_deleg, .s_vec, .m_vec, .s_commit, .m_commit, .cause_o, .epc_o,
      .tval_o, .htval_o, .mtval2_o, .prev_virt_o, .next_priv, .next_virt,
      .next_pc
   );

   task automatic chk(input string req, input logic [XL-1:0] act, input logic [XL-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (priv=%0d virt=%0d irq=%0d code=%0d)",
                  req, act, exp, cur_priv, cur_virt, trap_is_irq, trap_code);
      end
   endtask

   task automatic idle_checks(input string tag);
      chk({"R3 idle s_commit ", tag}, XL'(s_commit), '0);
      chk({"R3 idle m_commit ", tag}, XL'(m_commit), '0);
      chk({"R3 idle next_pc ", tag}, next_pc, cur_pc);
      chk({"R3 idle next_priv ", tag}, XL'(next_priv), XL'(cur_priv));
      chk({"R3 idle next_virt ", tag}, XL'(next_virt), XL'(cur_virt));
   endtask

   initial begin : watchdog
      #(CLK_P * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [1:0]    privs[3];
      logic [XL-1:0] mask, exp_pc, base, ide, ede;
      logic          deleg;
      privs[0] = 2'b00; privs[1] = 2'b01; privs[2] = 2'b11;

      // reset state: idle, nothing committed
      cur_pc = 32'h0000_1000; cur_priv = 2'b11; cur_virt = 1'b1;
      repeat (3) @(negedge clk);
      idle_checks("reset");
      rst_n = 1'b1;
      @(negedge clk);

      for (int vm = 0; vm < 4; vm++) begin
         ide = (32'hC3A5_0F69 << vm) | (32'hC3A5_0F69 >> (32 - vm));
         ede = ~ide ^ (32'h1 << (vm * 3));
         for (int p = 0; p < 3; p++) begin
            for (int v = 0; v < 2; v++) begin
               for (int irq = 0; irq < 2; irq++) begin
                  for (int code = 0; code < 32; code++) begin
                     for (int ha = 0; ha < 2; ha++) begin
                        @(negedge clk);
                        trap_valid    = 1'b1;
                        trap_is_irq   = irq[0];
                        trap_code     = CW'(code);
                        trap_has_addr = ha[0];
                        fault_addr    = 32'hDEAD_0000 | XL'(code);
                        gpa_addr      = 32'h1234_5000 ^ XL'(code * 17 + 1);
                        cur_pc        = 32'h8000_0000 + XL'(code * 8 + p * 2 + v * 4);
                        cur_priv      = privs[p];
                        cur_virt      = v[0];
                        irq_deleg     = ide;
                        exc_deleg     = ede;
                        s_vec         = 32'h0000_4000 | XL'(vm);
                        m_vec         = 32'h0010_8100 | XL'(vm);
                        #2;
                        // R1 / R2: expected delegation
                        mask  = irq ? ide : ede;
                        deleg = (privs[p] != 2'b11) && mask[code];
                        chk("R1 R2 s_commit", XL'(s_commit), XL'(deleg));
                        chk("R3 m_commit", XL'(m_commit), XL'(!deleg));
                        // R4
                        chk("R4 cause", cause_o, (XL'(irq) << (XL-1)) | XL'(code));
                        // R5
                        base   = deleg ? (32'h0000_4000) : (32'h0010_8100);
                        exp_pc = base + ((irq == 1 && vm == 1) ? XL'(code * 4) : 32'h0);
                        chk("R5 next_pc", next_pc, exp_pc);
                        // R6
                        chk("R6 tval", tval_o, (irq == 0 && ha == 1) ? fault_addr : 32'h0);
                        // R7
                        chk("R7 htval", htval_o, deleg ? gpa_addr : 32'h0);
                        chk("R7 mtval2", mtval2_o, deleg ? 32'h0 : gpa_addr);
                        // R8
                        if (deleg) chk("R8 prev_virt", XL'(prev_virt_o), XL'(v));
                        // R9
                        chk("R9 next_virt", XL'(next_virt), 32'h0);
                        // R10
                        chk("R10 epc", epc_o, cur_pc);
                        chk("R10 next_priv", XL'(next_priv), deleg ? 32'h1 : 32'h3);
                     end
                  end
               end
               // R3: an idle cycle in every privilege/virtualization state
               @(negedge clk);
               trap_valid = 1'b0;
               #2;
               idle_checks("sweep");
            end
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule